// File: doc/BRIEF.md
# DRAM Strobe Cycle Decoder

This block sits on the device side of an asynchronous DRAM strobe interface. It samples the active-low row strobe, column strobe, write enable and output enable, plus the shared address pins, on a fast system clock. From the order in which the strobe edges arrive it works out what kind of memory cycle the controller is running. The controller sends no explicit command.

Seven cycle kinds are recognised: read, early write, late write, read-modify-write, row-only refresh, column-before-row refresh and hidden refresh. The block latches the row address when the row strobe falls and the column address when the column strobe falls. It keeps an internal refresh row counter that supplies the row for the two counter-driven refresh kinds. It also works out when the device would drive its data bus.

Each classified cycle is reported as a single-clock pulse carrying a one-hot kind code, the row and the column. This makes the block suitable as the front end of a small memory model, or as a protocol checker beside a controller.

Top module: `dram_strobe_decoder`

## Requirements
- R1: After reset, `cyc_valid` and `data_oe` are 0, `cyc_type` is 0, and the first counter-driven refresh reports row 0.
- R2: `cyc_valid` is high for exactly one clock per classified cycle, and `cyc_type` is then one-hot: bit 0 read, bit 1 early write, bit 2 late write, bit 3 read-modify-write, bit 4 row-only refresh, bit 5 column-before-row refresh, bit 6 hidden refresh. `cyc_type` is 0 while `cyc_valid` is low.
- R3: A read is classified as follows. The row strobe falls with the column strobe high, which latches the row. The column strobe then falls with write enable high, which latches the column. The access is reported as a read, with the latched row and column, when the column strobe or the row strobe rises, provided data was driven during that access.
- R4: If write enable is already low when the column strobe falls, the cycle is reported as an early write at that column strobe fall, and `data_oe` stays 0 for the whole access.
- R5: If write enable falls while the column strobe is low and no data has been driven during the access, the cycle is reported as a late write at the write enable fall.
- R6: If data was driven during the access and write enable then falls while the column strobe is low, the cycle is reported as read-modify-write, and `data_oe` is 0 from then on.
- R7: If the row strobe rises with no column strobe fall since the row strobe fell, the cycle is reported as a row-only refresh. It carries the row taken from the pins, column 0, and `data_oe` is 0.
- R8: If the column strobe is low when the row strobe falls and no read is being held, the cycle is reported as a column-before-row refresh. Its row comes from the internal counter, the address pins are ignored, and the counter then increments, wrapping modulo 2^ROW_W.
- R9: If the column strobe stays low after a read and the row strobe is cycled, the cycle is reported as a hidden refresh with the counter row, the counter increments, and `data_oe` stays 1.
- R10: `data_oe` is 1 only while the column strobe and output enable are low, write enable is high, and the current access is a read. It drops when output enable rises or the column strobe rises; in particular, it is 0 whenever both strobes are high.
- R11: Every result (`cyc_valid`, `cyc_type`, `cyc_row`, `cyc_col`, `data_oe`) is registered and reflects an input change SYNC_STAGES+1 clocks later.
- R12: In page mode, several column strobe pulses within one row strobe low period are each classified separately, with the same latched row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low, asynchronous |
| cas_n | input | 1 | Column strobe, active low, asynchronous |
| we_n | input | 1 | Write enable, active low, asynchronous |
| oe_n | input | 1 | Output enable, active low, asynchronous |
| addr | input | ADDR_W | Shared row/column address pins |
| cyc_valid | output | 1 | One-clock pulse per classified cycle |
| cyc_type | output | 7 | One-hot cycle kind (see R2) |
| cyc_row | output | ROW_W | Row of the reported cycle |
| cyc_col | output | COL_W | Column of the reported cycle (0 for refresh kinds) |
| data_oe | output | 1 | Device would drive its data bus |

## Verification
With the default of two synchronizer stages, every result is due exactly three clocks after the input change that causes it: two flops synchronize the input and one registers the result. The bench drives each strobe change just after a falling clock edge. It then watches the next four falling edges. It requires `cyc_valid` to be low on the first, second and fourth of these, and compares the pulse, kind, row, column and `data_oe` on the third. A result that comes one clock early or late therefore shows up as a missing pulse, a stray pulse or a wrong `data_oe` value.

// File: rtl/dram_cyc_pkg.sv
// Package: shared cycle-kind encoding for the strobe decoder.
// Assumes the kind value doubles as the bit index of the one-hot report.
package dram_cyc_pkg;

    localparam int KIND_N = 7;

    typedef enum logic [2:0] {
        KIND_READ     = 3'd0,
        KIND_EARLY_WR = 3'd1,
        KIND_LATE_WR  = 3'd2,
        KIND_RMW      = 3'd3,
        KIND_RAS_ONLY = 3'd4,
        KIND_CBR      = 3'd5,
        KIND_HIDDEN   = 3'd6
    } cyc_kind_e;

    // Turn a kind value into its one-hot report vector.
    function automatic logic [KIND_N-1:0] kind_onehot(cyc_kind_e k);
        return KIND_N'(1) << k;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
// Module: multi-stage synchronizer for a vector of asynchronous inputs.
// Assumes the vector is stable across edges that matter for decoding, so
// that all bits of it arrive together. RST_VAL sets the value held in reset.
module strobe_sync #(
    parameter int             W       = 4,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] pipe [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            // One flop stage of the synchronizer chain.
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else if (g == 0) pipe[g] <= d;
                else pipe[g] <= pipe[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q = pipe[STAGES-1];

endmodule

// File: rtl/refresh_ctr.sv
// Module: internal refresh row counter.
// Assumes adv is a single-clock request; the row wraps modulo 2^W.
module refresh_ctr #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    output logic [W-1:0] row
);

    // Step the counter once per counter-driven refresh.
    always_ff @(posedge clk) begin
        if (!rst_n)   row <= '0;
        else if (adv) row <= row + W'(1);
    end

endmodule

// File: rtl/cycle_classifier.sv
// Module: classifies memory cycles from the order of synchronized strobe edges.
// Assumes active-low synchronized strobes, and that the controller never moves
// two strobes in the same sample. Produces registered reports and drive enable.
module cycle_classifier
    import dram_cyc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int ROW_W  = 12,
    parameter int COL_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_ras,
    input  logic              s_cas,
    input  logic              s_we,
    input  logic              s_oe,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [ROW_W-1:0]  ref_row,
    output logic              ref_adv,
    output logic              evt_valid,
    output cyc_kind_e         evt_kind,
    output logic [ROW_W-1:0]  evt_row,
    output logic [COL_W-1:0]  evt_col,
    output logic              drive_en
);

    logic p_ras, p_cas, p_we, p_oe;
    logic ras_fall, ras_rise, cas_fall, cas_rise, we_fall;
    logic row_act, cas_seen, acc_pend, acc_read, rd_ok;
    logic open_rd, drive_now;
    logic [ROW_W-1:0] row_q;
    logic [COL_W-1:0] col_q;

    // Keep the previous strobe sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_ras <= 1'b1; p_cas <= 1'b1; p_we <= 1'b1; p_oe <= 1'b1;
        end else begin
            p_ras <= s_ras; p_cas <= s_cas; p_we <= s_we; p_oe <= s_oe;
        end
    end

    // Decode edges and the data-drive condition for this sample.
    always_comb begin
        ras_fall  = p_ras & ~s_ras;
        ras_rise  = ~p_ras & s_ras;
        cas_fall  = p_cas & ~s_cas;
        cas_rise  = ~p_cas & s_cas;
        we_fall   = p_we & ~s_we;
        open_rd   = cas_fall & row_act & s_we;
        drive_now = ~s_cas & ~s_oe & s_we & (rd_ok | open_rd);
        ref_adv   = ras_fall & ~s_cas;
    end

    // Track the cycle state and emit one report per classified cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_act   <= 1'b0;
            cas_seen  <= 1'b0;
            acc_pend  <= 1'b0;
            acc_read  <= 1'b0;
            rd_ok     <= 1'b0;
            row_q     <= '0;
            col_q     <= '0;
            evt_valid <= 1'b0;
            evt_kind  <= KIND_READ;
            evt_row   <= '0;
            evt_col   <= '0;
            drive_en  <= 1'b0;
        end else begin
            evt_valid <= 1'b0;
            drive_en  <= drive_now;
            if (drive_now && acc_pend) acc_read <= 1'b1;

            if (ras_fall) begin
                if (!s_cas) begin
                    evt_valid <= 1'b1;
                    evt_kind  <= rd_ok ? KIND_HIDDEN : KIND_CBR;
                    evt_row   <= ref_row;
                    evt_col   <= '0;
                end else begin
                    row_act  <= 1'b1;
                    cas_seen <= 1'b0;
                    row_q    <= s_addr[ROW_W-1:0];
                end
            end

            if (cas_fall && row_act) begin
                cas_seen <= 1'b1;
                col_q    <= s_addr[COL_W-1:0];
                if (!s_we) begin
                    evt_valid <= 1'b1;
                    evt_kind  <= KIND_EARLY_WR;
                    evt_row   <= row_q;
                    evt_col   <= s_addr[COL_W-1:0];
                end else begin
                    acc_pend <= 1'b1;
                    acc_read <= ~s_oe;
                    rd_ok    <= 1'b1;
                end
            end

            if (we_fall) begin
                rd_ok <= 1'b0;
                if (acc_pend && !s_cas) begin
                    evt_valid <= 1'b1;
                    evt_kind  <= acc_read ? KIND_RMW : KIND_LATE_WR;
                    evt_row   <= row_q;
                    evt_col   <= col_q;
                    acc_pend  <= 1'b0;
                    acc_read  <= 1'b0;
                end
            end else if ((cas_rise || ras_rise) && acc_pend) begin
                if (acc_read) begin
                    evt_valid <= 1'b1;
                    evt_kind  <= KIND_READ;
                    evt_row   <= row_q;
                    evt_col   <= col_q;
                end
                acc_pend <= 1'b0;
                acc_read <= 1'b0;
            end

            if (cas_rise) rd_ok <= 1'b0;

            if (ras_rise) begin
                row_act <= 1'b0;
                if (row_act && !cas_seen) begin
                    evt_valid <= 1'b1;
                    evt_kind  <= KIND_RAS_ONLY;
                    evt_row   <= row_q;
                    evt_col   <= '0;
                end
            end
        end
    end

endmodule

// File: rtl/dram_strobe_decoder.sv
// Module: top of the strobe cycle decoder.
// Synchronizes the asynchronous strobes and address, classifies each cycle,
// keeps the refresh row counter and reports one-hot kind, row and column.
// Assumes address and strobes pass through equal synchronizer depth.
module dram_strobe_decoder
    import dram_cyc_pkg::*;
#(
    parameter int ADDR_W      = 12,
    parameter int ROW_W       = 12,
    parameter int COL_W       = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cyc_valid,
    output logic [6:0]        cyc_type,
    output logic [ROW_W-1:0]  cyc_row,
    output logic [COL_W-1:0]  cyc_col,
    output logic              data_oe
);

    localparam int STRB_W = 4;

    logic [STRB_W-1:0] s_strb;
    logic [ADDR_W-1:0] s_addr;
    logic              s_ras, s_cas, s_we, s_oe;
    logic [ROW_W-1:0]  ref_row;
    logic              ref_adv;
    logic              evt_valid;
    cyc_kind_e         evt_kind;

    strobe_sync #(.W(STRB_W), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync_strb (
        .clk(clk), .rst_n(rst_n), .d({ras_n, cas_n, we_n, oe_n}), .q(s_strb)
    );

    strobe_sync #(.W(ADDR_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_addr (
        .clk(clk), .rst_n(rst_n), .d(addr), .q(s_addr)
    );

    // Split the synchronized strobe vector.
    always_comb begin
        {s_ras, s_cas, s_we, s_oe} = s_strb;
    end

    refresh_ctr #(.W(ROW_W)) u_ref (
        .clk(clk), .rst_n(rst_n), .adv(ref_adv), .row(ref_row)
    );

    cycle_classifier #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_cls (
        .clk(clk), .rst_n(rst_n),
        .s_ras(s_ras), .s_cas(s_cas), .s_we(s_we), .s_oe(s_oe), .s_addr(s_addr),
        .ref_row(ref_row), .ref_adv(ref_adv),
        .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_row(cyc_row), .evt_col(cyc_col), .drive_en(data_oe)
    );

    // Expand the registered kind into the one-hot report.
    always_comb begin
        cyc_valid = evt_valid;
        cyc_type  = evt_valid ? kind_onehot(evt_kind) : '0;
    end

endmodule

// File: rtl/dram_strobe_decoder_chk.sv
// Module: assertion checker bound into the strobe decoder top.
// Assumes it sees the top's ports and its synchronized column strobe.
module dram_strobe_decoder_chk #(
    parameter int ROW_W = 12,
    parameter int COL_W = 10
) (
    input logic             clk,
    input logic             rst_n,
    input logic             s_cas,
    input logic             cyc_valid,
    input logic [6:0]       cyc_type,
    input logic [ROW_W-1:0] cyc_row,
    input logic [COL_W-1:0] cyc_col,
    input logic             data_oe
);

    logic             seen_ref;
    logic [ROW_W-1:0] last_ref;
    logic             is_ref;

    assign is_ref = cyc_valid && (cyc_type[5] || cyc_type[6]);

    // Remember the row of the most recent counter-driven refresh.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_ref <= 1'b0;
            last_ref <= '0;
        end else if (is_ref) begin
            seen_ref <= 1'b1;
            last_ref <= cyc_row;
        end
    end

    // R2: one-hot kind with a valid report, zero otherwise.
    a_r2_onehot_kind: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |-> $countones(cyc_type) == 1);
    a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid |-> cyc_type == 7'd0);
    // R2: a report lasts a single clock.
    a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_valid |=> !cyc_valid);
    // R10: a high column strobe stops the drive next clock.
    a_r10_cas_high_off: assert property (@(posedge clk) disable iff (!rst_n)
        s_cas |=> !data_oe);
    // R4: an early write never drives the bus.
    a_r4_early_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type[1]) |-> !data_oe);
    // R7: a row-only refresh carries column 0 and no drive.
    a_r7_rowonly_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type[4]) |-> (cyc_col == '0 && !data_oe));
    // R9: a hidden refresh keeps the read data driven.
    a_r9_hidden_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid && cyc_type[6]) |-> data_oe);
    // R8: successive counter refreshes use successive rows.
    a_r8_counter_step: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ref && seen_ref) |-> cyc_row == last_ref + ROW_W'(1));

endmodule

bind dram_strobe_decoder dram_strobe_decoder_chk #(.ROW_W(ROW_W), .COL_W(COL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_cas(s_cas),
    .cyc_valid(cyc_valid), .cyc_type(cyc_type), .cyc_row(cyc_row),
    .cyc_col(cyc_col), .data_oe(data_oe)
);

// File: tb/dram_strobe_decoder_bench.sv
// Bench: directed and seeded random strobe sequences, each change checked
// three clocks later against expectations derived from the requirements.
module dram_strobe_decoder_bench;

    localparam int ADDR_W = 6;
    localparam int ROW_W  = 6;
    localparam int COL_W  = 5;
    localparam int LAT    = 3;

    // Bench-side kind numbering, from R2.
    localparam int K_NONE = -1;
    localparam int K_RD   = 0;
    localparam int K_EW   = 1;
    localparam int K_LW   = 2;
    localparam int K_RMW  = 3;
    localparam int K_RO   = 4;
    localparam int K_CBR  = 5;
    localparam int K_HID  = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [ADDR_W-1:0] addr = '0;
    logic cyc_valid, data_oe;
    logic [6:0] cyc_type;
    logic [ROW_W-1:0] cyc_row;
    logic [COL_W-1:0] cyc_col;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;
    logic [ROW_W-1:0] exp_ref = '0;

    always #5 clk = ~clk;

    dram_strobe_decoder #(.ADDR_W(ADDR_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_dram_strobe_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
        .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid), .cyc_type(cyc_type),
        .cyc_row(cyc_row), .cyc_col(cyc_col), .data_oe(data_oe)
    );

    function automatic logic [6:0] exp_type(int k);
        return (k < 0) ? 7'd0 : (7'd1 << k);
    endfunction

    task automatic check(bit ok, string req, string what, string act, string expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %s expected %s", req, what, act, expv);
        end
    endtask

    // Apply one input change, then check the result on the LAT-th falling edge
    // and require silence on the others.
    task automatic step(input logic r, c, w, o, input logic [ADDR_W-1:0] a,
                        input int kind, input logic [ROW_W-1:0] er,
                        input logic [COL_W-1:0] ec, input bit eoe, input string req);
        ras_n = r; cas_n = c; we_n = w; oe_n = o; addr = a;
        for (int i = 1; i <= LAT + 1; i++) begin
            @(negedge clk);
            if (i == LAT) begin
                check(cyc_valid == (kind >= 0) && cyc_type == exp_type(kind), req, "kind",
                      $sformatf("%0b/%b", cyc_valid, cyc_type),
                      $sformatf("%0b/%b", kind >= 0, exp_type(kind)));
                if (kind >= 0)
                    check(cyc_row == er && cyc_col == ec, req, "row/col",
                          $sformatf("%0d/%0d", cyc_row, cyc_col), $sformatf("%0d/%0d", er, ec));
                check(data_oe == eoe, req, "data_oe", $sformatf("%0b", data_oe), $sformatf("%0b", eoe));
            end else if (cyc_valid) begin
                check(1'b0, "R11", "stray pulse", $sformatf("i=%0d", i), "none");
            end
        end
    endtask

    task automatic page_read(input logic [ROW_W-1:0] row, input int ncol);
        step(0, 1, 1, 0, ADDR_W'(row), K_NONE, 0, 0, 0, "R3");
        for (int k = 0; k < ncol; k++) begin
            logic [COL_W-1:0] col = COL_W'($urandom);
            step(0, 0, 1, 0, ADDR_W'(col), K_NONE, 0, 0, 1, "R3");
            step(0, 1, 1, 0, ADDR_W'(col), K_RD, row, col, 0, (k > 0) ? "R12" : "R3");
        end
        step(1, 1, 1, 1, '0, K_NONE, 0, 0, 0, "R3");
    endtask

    task automatic early_write(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        step(0, 1, 1, 0, ADDR_W'(row), K_NONE, 0, 0, 0, "R4");
        step(0, 1, 0, 0, ADDR_W'(row), K_NONE, 0, 0, 0, "R4");
        step(0, 0, 0, 0, ADDR_W'(col), K_EW, row, col, 0, "R4");
        step(0, 1, 0, 0, ADDR_W'(col), K_NONE, 0, 0, 0, "R4");
        step(1, 1, 1, 1, '0, K_NONE, 0, 0, 0, "R4");
    endtask

    task automatic late_write(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        step(0, 1, 1, 1, ADDR_W'(row), K_NONE, 0, 0, 0, "R5");
        step(0, 0, 1, 1, ADDR_W'(col), K_NONE, 0, 0, 0, "R5");
        step(0, 0, 0, 1, ADDR_W'(col), K_LW, row, col, 0, "R5");
        step(0, 1, 0, 1, ADDR_W'(col), K_NONE, 0, 0, 0, "R5");
        step(1, 1, 1, 1, '0, K_NONE, 0, 0, 0, "R5");
    endtask

    task automatic rmw(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        step(0, 1, 1, 0, ADDR_W'(row), K_NONE, 0, 0, 0, "R6");
        step(0, 0, 1, 0, ADDR_W'(col), K_NONE, 0, 0, 1, "R6");
        step(0, 0, 1, 1, ADDR_W'(col), K_NONE, 0, 0, 0, "R10");
        step(0, 0, 0, 1, ADDR_W'(col), K_RMW, row, col, 0, "R6");
        step(0, 1, 0, 1, ADDR_W'(col), K_NONE, 0, 0, 0, "R6");
        step(1, 1, 1, 1, '0, K_NONE, 0, 0, 0, "R6");
    endtask

    task automatic ras_only(input logic [ROW_W-1:0] row);
        step(0, 1, 1, 0, ADDR_W'(row), K_NONE, 0, 0, 0, "R7");
        step(1, 1, 1, 0, ADDR_W'(row), K_RO, row, 0, 0, "R7");
    endtask

    task automatic cbr();
        step(1, 0, 1, 0, ADDR_W'($urandom), K_NONE, 0, 0, 0, "R8");
        step(0, 0, 1, 0, ADDR_W'($urandom), K_CBR, exp_ref, 0, 0, "R8");
        exp_ref = exp_ref + ROW_W'(1);
        step(1, 0, 1, 0, '0, K_NONE, 0, 0, 0, "R8");
        step(1, 1, 1, 1, '0, K_NONE, 0, 0, 0, "R10");
    endtask

    task automatic hidden(input logic [ROW_W-1:0] row, input logic [COL_W-1:0] col);
        step(0, 1, 1, 0, ADDR_W'(row), K_NONE, 0, 0, 0, "R9");
        step(0, 0, 1, 0, ADDR_W'(col), K_NONE, 0, 0, 1, "R9");
        step(1, 0, 1, 0, ADDR_W'(col), K_RD, row, col, 1, "R9");
        step(0, 0, 1, 0, ADDR_W'($urandom), K_HID, exp_ref, 0, 1, "R9");
        exp_ref = exp_ref + ROW_W'(1);
        step(1, 0, 1, 0, '0, K_NONE, 0, 0, 1, "R9");
        step(1, 1, 1, 0, '0, K_NONE, 0, 0, 0, "R10");
        step(1, 1, 1, 1, '0, K_NONE, 0, 0, 0, "R10");
    endtask

    initial begin
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(!cyc_valid && cyc_type == 7'd0 && !data_oe, "R1", "reset outputs",
              $sformatf("%0b/%b/%0b", cyc_valid, cyc_type, data_oe), "0/0000000/0");
        // R1 and R8: first refresh uses row 0.
        cbr();
        page_read(6'd17, 1);
        page_read(6'd42, 3);
        early_write(6'd5, 5'd9);
        late_write(6'd63, 5'd31);
        rmw(6'd0, 5'd1);
        ras_only(6'd33);
        hidden(6'd12, 5'd20);
        // R8: run the counter past its wrap.
        for (int k = 0; k < 66; k++) cbr();
        for (int k = 0; k < 250; k++) begin
            logic [ROW_W-1:0] row = ROW_W'($urandom);
            logic [COL_W-1:0] col = COL_W'($urandom);
            case ($urandom_range(0, 6))
                0: page_read(row, $urandom_range(1, 3));
                1: early_write(row, col);
                2: late_write(row, col);
                3: rmw(row, col);
                4: ras_only(row);
                5: cbr();
                default: hidden(row, col);
            endcase
        end
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule